// File: doc/BRIEF.md
# Periodic Write-Back Sequencer

This block decides which memory writes follow one periodic USB transaction, and in what order they go out. Before the transaction runs, the scheduler loads a write set. The write set gives the number of inbound data beats to store, whether a queue-head overlay must be refreshed (the first transaction of a queue element has completed), and whether the status must go to a split-transaction descriptor pair linked by a backpointer. The sequencer then waits for the execution outcome: how many packets actually ran on the bus and whether a late-start check cut the transaction short.

If nothing ran, the write set is discarded and no write is issued. Otherwise the block emits a strict sequence of write commands over a valid/acknowledge handshake. Each command carries a 2-bit target code. Status commands also carry the completed packet count and a partial flag, so a high-bandwidth transaction that was stopped after some packets still reports what it did. The block takes one write set at a time and stays busy until its last command is accepted.

Top module: `pwb_top`

## Requirements
- R1: A write set is loaded when `set_valid` is high and `busy` is low. `busy` rises in the cycle after loading and falls in the cycle after the final command is acknowledged, or after a discarded outcome. `set_valid` while busy is ignored.
- R2: No write command is presented before the execution outcome (`exec_valid`) for the loaded write set has been taken.
- R3: An outcome with `exec_pkts` equal to 0 is discarded, with or without a late-start failure. No command is issued, and `busy` is low in the next cycle.
- R4: Commands come out in a fixed order. First come `set_beats` in-data writes (target 0). Then one overlay write (target 1) if `set_overlay` is set. Then, if `set_pair` is set, the status write to the descriptor named by the backpointer (target 2). Last comes the status write to the descriptor that holds the backpointer, or to the sole descriptor (target 3).
- R5: Status commands (target bit 1 set) carry `exec_pkts` on `wr_pkts` and the late-start failure on `wr_partial`. In-data and overlay commands show 0 on both. A late-start failure with at least one completed packet still issues the full sequence of R4.
- R6: A presented command keeps `wr_valid`, `wr_target`, `wr_pkts` and `wr_partial` unchanged until `wr_ack` is high at a clock edge.
- R7: `exec_valid` is ignored unless a loaded write set is waiting for its outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| set_valid | input | 1 | Load a write set |
| set_beats | input | BEAT_W | Number of in-data writes |
| set_overlay | input | 1 | Queue-head overlay write required |
| set_pair | input | 1 | Status goes to a backpointer-linked descriptor pair |
| exec_valid | input | 1 | Execution outcome is present |
| exec_late_fail | input | 1 | Late-start check failed |
| exec_pkts | input | PKT_W | Packets completed on the bus |
| wr_ack | input | 1 | Current write command is accepted |
| busy | output | 1 | A write set is held |
| wr_valid | output | 1 | Write command presented |
| wr_target | output | 2 | Target code of the command |
| wr_pkts | output | PKT_W | Completed packet count, on status commands |
| wr_partial | output | 1 | Late-start-failure flag, on status commands |

## Verification
The assertions assume the scheduler pulses `exec_valid` at most once per loaded write set, and that `wr_ack` may stall for any number of cycles but is never required for progress outside a presented command. The driver always waits for `busy` to fall before it offers a new set and sends exactly one outcome for each set. It also sends deliberate stray loads and outcomes at moments when the block must ignore them. The acknowledge pattern mixes stalls and back-to-back accepts, so both the hold rule and the ordering are seen under back-pressure.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  typedef enum logic [1:0] {
    TGT_IN_DATA  = 2'd0,
    TGT_OVERLAY  = 2'd1,
    TGT_STAT_REF = 2'd2,
    TGT_STAT_OWN = 2'd3
  } pwb_tgt_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_DATA, ST_OVL, ST_SREF, ST_SOWN
  } pwb_st_e;

  // Phase that follows 'cur' once its writes are done; ST_WAIT means "before any write".
  function automatic pwb_st_e pwb_after(pwb_st_e cur, logic has_data, logic ovl, logic pair);
    if (cur == ST_WAIT && has_data) return ST_DATA;
    if ((cur == ST_WAIT || cur == ST_DATA) && ovl) return ST_OVL;
    if (cur != ST_SREF && cur != ST_SOWN && pair) return ST_SREF;
    if (cur != ST_SOWN) return ST_SOWN;
    return ST_IDLE;
  endfunction

  function automatic logic [1:0] pwb_tgt_of(pwb_st_e st);
    case (st)
      ST_OVL:  return TGT_OVERLAY;
      ST_SREF: return TGT_STAT_REF;
      ST_SOWN: return TGT_STAT_OWN;
      default: return TGT_IN_DATA;
    endcase
  endfunction

  function automatic logic pwb_is_emit(pwb_st_e st);
    return (st == ST_DATA) || (st == ST_OVL) || (st == ST_SREF) || (st == ST_SOWN);
  endfunction

endpackage

// File: rtl/pwb_set_reg.sv
module pwb_set_reg #(
  parameter int BEAT_W = 4,
  parameter int PKT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_take,
  input  logic [BEAT_W-1:0] set_beats,
  input  logic              set_overlay,
  input  logic              set_pair,
  input  logic              exec_take,
  input  logic              exec_late_fail,
  input  logic [PKT_W-1:0]  exec_pkts,
  output logic [BEAT_W-1:0] q_beats,
  output logic              q_overlay,
  output logic              q_pair,
  output logic              q_partial,
  output logic [PKT_W-1:0]  q_pkts
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_beats   <= '0;
      q_overlay <= 1'b0;
      q_pair    <= 1'b0;
      q_partial <= 1'b0;
      q_pkts    <= '0;
    end else begin
      if (set_take) begin
        q_beats   <= set_beats;
        q_overlay <= set_overlay;
        q_pair    <= set_pair;
      end
      if (exec_take) begin
        q_partial <= exec_late_fail;
        q_pkts    <= exec_pkts;
      end
    end
  end

endmodule

// File: rtl/pwb_seq.sv
module pwb_seq
  import pwb_pkg::*;
#(
  parameter int BEAT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_take,
  input  logic              exec_take,
  input  logic              exec_drop,
  input  logic [BEAT_W-1:0] beats,
  input  logic              ovl,
  input  logic              pair,
  input  logic              wr_ack,
  output logic              waiting,
  output logic              emit,
  output logic              busy,
  output logic [1:0]        tgt
);

  pwb_st_e           st, st_n;
  logic [BEAT_W-1:0] left_q;
  logic              step_done;

  assign step_done = emit && wr_ack;

  always_comb begin
    st_n = st;
    case (st)
      ST_IDLE: if (set_take) st_n = ST_WAIT;
      ST_WAIT: if (exec_take)
                 st_n = exec_drop ? ST_IDLE : pwb_after(ST_WAIT, beats != '0, ovl, pair);
      ST_DATA: if (step_done && left_q == BEAT_W'(1))
                 st_n = pwb_after(ST_DATA, 1'b0, ovl, pair);
      default: if (step_done) st_n = pwb_after(st, 1'b0, ovl, pair);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      left_q <= '0;
    end else begin
      st <= st_n;
      if (st == ST_WAIT && exec_take) left_q <= beats;
      else if (st == ST_DATA && step_done) left_q <= left_q - BEAT_W'(1);
    end
  end

  assign waiting = (st == ST_WAIT);
  assign emit    = pwb_is_emit(st);
  assign busy    = (st != ST_IDLE);
  assign tgt     = pwb_tgt_of(st);

  // R6: command held under back-pressure
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    emit && !wr_ack |=> emit && $stable(tgt));

  // R4: targets never step backwards inside one sequence
  a_r4_order: assert property (@(posedge clk) disable iff (!rst_n)
    emit && $past(emit) |-> tgt >= $past(tgt));

  // R4, R1: owning-descriptor status is the last command, then idle
  a_r4_last: assert property (@(posedge clk) disable iff (!rst_n)
    emit && wr_ack && tgt == TGT_STAT_OWN |=> !emit && !busy);

endmodule

// File: rtl/pwb_top.sv
module pwb_top
  import pwb_pkg::*;
#(
  parameter int BEAT_W = 4,
  parameter int PKT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_valid,
  input  logic [BEAT_W-1:0] set_beats,
  input  logic              set_overlay,
  input  logic              set_pair,
  input  logic              exec_valid,
  input  logic              exec_late_fail,
  input  logic [PKT_W-1:0]  exec_pkts,
  input  logic              wr_ack,
  output logic              busy,
  output logic              wr_valid,
  output logic [1:0]        wr_target,
  output logic [PKT_W-1:0]  wr_pkts,
  output logic              wr_partial
);

  logic              set_take, exec_take, exec_drop, waiting;
  logic [BEAT_W-1:0] q_beats;
  logic              q_overlay, q_pair, q_partial;
  logic [PKT_W-1:0]  q_pkts;
  logic              is_status;

  assign set_take  = set_valid && !busy;
  assign exec_take = exec_valid && waiting;
  assign exec_drop = (exec_pkts == '0);

  pwb_set_reg #(.BEAT_W(BEAT_W), .PKT_W(PKT_W)) set_reg_i (
    .clk(clk), .rst_n(rst_n),
    .set_take(set_take), .set_beats(set_beats), .set_overlay(set_overlay), .set_pair(set_pair),
    .exec_take(exec_take), .exec_late_fail(exec_late_fail), .exec_pkts(exec_pkts),
    .q_beats(q_beats), .q_overlay(q_overlay), .q_pair(q_pair),
    .q_partial(q_partial), .q_pkts(q_pkts)
  );

  pwb_seq #(.BEAT_W(BEAT_W)) seq_i (
    .clk(clk), .rst_n(rst_n),
    .set_take(set_take), .exec_take(exec_take), .exec_drop(exec_drop),
    .beats(q_beats), .ovl(q_overlay), .pair(q_pair), .wr_ack(wr_ack),
    .waiting(waiting), .emit(wr_valid), .busy(busy), .tgt(wr_target)
  );

  assign is_status  = wr_target[1];
  assign wr_pkts    = is_status ? q_pkts : '0;
  assign wr_partial = is_status ? q_partial : 1'b0;

  // R2: a command sequence only starts right after an outcome was taken
  a_r2_exec_first: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !$past(wr_valid) |-> $past(exec_take));

  // R3: an empty outcome releases the block without any write
  a_r3_drop: assert property (@(posedge clk) disable iff (!rst_n)
    exec_take && exec_drop |=> !wr_valid && !busy);

  // R5: status commands always report at least one completed packet
  a_r5_stat_pkts: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && is_status |-> wr_pkts != '0);

  // R1: commands only while busy
  a_r1_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> busy);

endmodule

// File: tb/pwb_top_tb.sv
module pwb_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BEAT_W = 4;
  localparam int PKT_W  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic set_valid = 1'b0, set_overlay = 1'b0, set_pair = 1'b0;
  logic [BEAT_W-1:0] set_beats = '0;
  logic exec_valid = 1'b0, exec_late_fail = 1'b0;
  logic [PKT_W-1:0] exec_pkts = '0;
  logic wr_ack = 1'b0;
  logic busy, wr_valid, wr_partial;
  logic [1:0] wr_target;
  logic [PKT_W-1:0] wr_pkts;

  int n_run = 0, n_fail = 0;
  int ack_cyc = 0;
  bit finished = 1'b0;
  logic [PKT_W+2:0] exp_q[$];   // {target, partial, pkts}

  always #(CLK_PERIOD/2) clk = ~clk;

  pwb_top #(.BEAT_W(BEAT_W), .PKT_W(PKT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .set_valid(set_valid), .set_beats(set_beats),
    .set_overlay(set_overlay), .set_pair(set_pair), .exec_valid(exec_valid),
    .exec_late_fail(exec_late_fail), .exec_pkts(exec_pkts), .wr_ack(wr_ack),
    .busy(busy), .wr_valid(wr_valid), .wr_target(wr_target),
    .wr_pkts(wr_pkts), .wr_partial(wr_partial)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  // Monitor: picks the acknowledge for the coming edge and compares the accepted command
  always @(negedge clk) begin
    if (rst_n) begin
      ack_cyc++;
      wr_ack = (ack_cyc % 4) != 1;
      if (wr_valid && exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected write", int'(wr_target), -1);
      end else if (wr_valid && wr_ack) begin
        logic [PKT_W+2:0] e;
        e = exp_q.pop_front();
        check({wr_target, wr_partial, wr_pkts} == e, "R4/R5 command",
              int'({wr_target, wr_partial, wr_pkts}), int'(e));
      end
    end
  end

  // Driver: load a write set, wait, deliver the outcome and queue the expected commands
  task automatic run_txn(input int beats, input bit ovl, input bit pair,
                         input bit late, input int pkts, input int gap, input bit poke);
    while (busy) tick();
    set_valid = 1'b1; set_beats = BEAT_W'(beats); set_overlay = ovl; set_pair = pair;
    tick();
    set_valid = 1'b0;
    check(busy == 1'b1, "R1 busy after load", int'(busy), 1);
    for (int i = 0; i < gap; i++) begin
      if (poke && i == 0) begin   // R1: stray load while busy must be ignored
        set_valid = 1'b1; set_beats = 4'd7; set_overlay = 1'b1; set_pair = 1'b1;
      end else set_valid = 1'b0;
      tick();
      check(wr_valid == 1'b0, "R2 no write before outcome", int'(wr_valid), 0);
    end
    set_valid = 1'b0;
    if (pkts != 0) begin
      for (int b = 0; b < beats; b++) exp_q.push_back({2'd0, 1'b0, PKT_W'(0)});
      if (ovl)  exp_q.push_back({2'd1, 1'b0, PKT_W'(0)});
      if (pair) exp_q.push_back({2'd2, late, PKT_W'(pkts)});
      exp_q.push_back({2'd3, late, PKT_W'(pkts)});
    end
    exec_valid = 1'b1; exec_late_fail = late; exec_pkts = PKT_W'(pkts);
    tick();
    exec_valid = 1'b0;
    if (pkts == 0) begin
      check(busy == 1'b0 && wr_valid == 1'b0, "R3 discarded outcome", int'({busy, wr_valid}), 0);
    end else begin
      while (exp_q.size() != 0) tick();
      tick();
      check(busy == 1'b0, "R1 busy falls after final ack", int'(busy), 0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check(busy == 1'b0 && wr_valid == 1'b0, "R1 reset state", int'({busy, wr_valid}), 0);

    // R7: outcome with nothing loaded is ignored
    exec_valid = 1'b1; exec_pkts = 2'd1;
    tick();
    exec_valid = 1'b0;
    tick();
    check(busy == 1'b0 && wr_valid == 1'b0, "R7 stray outcome", int'({busy, wr_valid}), 0);

    run_txn(3, 1'b1, 1'b0, 1'b0, 1, 2, 1'b0);   // R4 data, overlay, status
    run_txn(0, 1'b0, 1'b1, 1'b0, 2, 1, 1'b0);   // R4 backpointer pair order
    run_txn(2, 1'b1, 1'b1, 1'b1, 2, 3, 1'b0);   // R5 partial high-bandwidth
    run_txn(4, 1'b1, 1'b1, 1'b1, 0, 2, 1'b0);   // R3 late fail before run
    run_txn(1, 1'b0, 1'b0, 1'b0, 0, 1, 1'b0);   // R3 nothing executed
    run_txn(15, 1'b0, 1'b0, 1'b0, 3, 4, 1'b1);  // R1 ignored load, R4 max beats
    run_txn(0, 1'b1, 1'b0, 1'b0, 1, 0, 1'b0);   // R4 overlay only, R2 zero gap
    run_txn(1, 1'b0, 1'b1, 1'b1, 1, 1, 1'b0);   // R5 partial with pair

    // R7: outcome while commands are flowing is ignored
    set_valid = 1'b1; set_beats = 4'd5; set_overlay = 1'b0; set_pair = 1'b0;
    tick();
    set_valid = 1'b0;
    for (int b = 0; b < 5; b++) exp_q.push_back({2'd0, 1'b0, PKT_W'(0)});
    exp_q.push_back({2'd3, 1'b0, PKT_W'(2)});
    exec_valid = 1'b1; exec_late_fail = 1'b0; exec_pkts = 2'd2;
    tick();
    exec_late_fail = 1'b1; exec_pkts = 2'd0;    // still high: must not re-capture
    tick();
    exec_valid = 1'b0;
    while (exp_q.size() != 0) tick();
    tick();
    check(busy == 1'b0, "R7 outcome during writes ignored", int'(busy), 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule